// File: doc/BRIEF.md
# Trigger Run-Length Precedence Monitor

This block watches two single-bit inputs on one clock: a trigger and an event. It keeps a running count of how many clocks in a row the trigger has been high. Whenever the event goes from low to high, the block checks that the trigger run which ended just before that edge was exactly the configured length. A run that is too short, too long or missing is a violation. The check also catches an event that rises partway through a run, before the run has reached the required length.

A violation produces a one-clock pulse and sets a sticky flag that stays set until reset. The live run count is also an output. The counter saturates at the top of its range, so a very long trigger run can never wrap round to a value that looks like a match. The block is meant to sit beside a datapath as a synthesizable protocol watchdog.

Top module: `trig_prec_checker`

## Requirements
- R1: While reset is high, and on the first clock after it, the run count is 0 and both error outputs are 0.
- R2: On each clock where trigger is sampled high, the run count grows by one, until it reaches its ceiling.
- R3: On any clock where trigger is sampled low, the run count becomes 0.
- R4: The run count stops at its ceiling, all ones (7 with the default 3-bit count), while trigger stays high, and it does not wrap.
- R5: When event is sampled high after being sampled low on the previous clock, and the run count shown before that clock equals RUN_LEN (default 4), no error is raised.
- R6: An event rising edge seen while the run count is below RUN_LEN raises the error pulse and sets the sticky flag on the output after that clock edge. This covers an edge that comes early in a run and an edge that comes with no run at all.
- R7: An event rising edge seen while the run count is above RUN_LEN, up to and including the ceiling, also raises the error pulse and sets the sticky flag.
- R8: While event stays high, or stays low, no check is made and no error pulse is produced.
- R9: The error pulse lasts exactly one clock for each violation. The sticky flag stays set until reset.
- R10: An event that is already high when reset is released is not treated as a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Trigger level being counted |
| evt_i | input | 1 | Event level; a low-to-high change starts a check |
| err_sticky_o | output | 1 | Set by any violation; cleared only by reset |
| err_pulse_o | output | 1 | High for one clock after each violating edge |
| run_cnt_o | output | CNT_W | Consecutive trigger-high clocks, saturating |

## Verification
Every output is a register, so each result appears one edge after the inputs that cause it. The run count reflects the trigger sampled at that edge. The pulse and sticky flag reflect the event edge and the count that were visible before that edge. The bench changes the inputs one nanosecond after a rising edge and reads all three outputs one nanosecond after the next rising edge. Its hand-worked expectations therefore always compare the count held before an edge with the verdict shown after it. The directed tests apply the same one-edge rule to saturation, to the clocks just after reset and to an event held high through reset.

// File: rtl/trig_prec_pkg.sv
package trig_prec_pkg;

    typedef enum logic [1:0] {
        VERD_IDLE  = 2'd0,
        VERD_MATCH = 2'd1,
        VERD_MISS  = 2'd2
    } verdict_e;

    typedef struct packed {
        logic pulse;
        logic sticky;
    } err_flags_t;

    function automatic verdict_e classify(input logic edge_seen, input logic len_ok);
        if (!edge_seen)
            return VERD_IDLE;
        else if (len_ok)
            return VERD_MATCH;
        else
            return VERD_MISS;
    endfunction

    function automatic err_flags_t next_flags(input err_flags_t cur, input verdict_e v);
        err_flags_t n;
        n.pulse  = (v == VERD_MISS);
        n.sticky = cur.sticky | (v == VERD_MISS);
        return n;
    endfunction

endpackage

// File: rtl/trig_run_counter.sv
module trig_run_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_CEIL = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (!trig_i)
            cnt_q <= '0;
        else if (cnt_q != CNT_CEIL)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !trig_i |=> (cnt_q == '0)); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (trig_i && cnt_q != CNT_CEIL) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2
    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (trig_i && cnt_q == CNT_CEIL) |=> (cnt_q == CNT_CEIL)); // R4
endmodule

// File: rtl/evt_edge_detect.sv
module evt_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    output logic rise_o
);
    logic evt_q;

    // Reset preloads "seen high" so a level already present is not an edge.
    always_ff @(posedge clk) begin
        if (rst)
            evt_q <= 1'b1;
        else
            evt_q <= evt_i;
    end

    assign rise_o = evt_i & ~evt_q;

    AST_NO_RISE_AFTER_RST: assert property (@(posedge clk)
        rst |=> !rise_o); // R10
    AST_HELD_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        evt_i |=> !rise_o); // R8
endmodule

// File: rtl/prec_verdict.sv
module prec_verdict
    import trig_prec_pkg::*;
#(
    parameter int CNT_W   = 3,
    parameter int RUN_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             pulse_o,
    output logic             sticky_o
);
    localparam logic [CNT_W-1:0] LEN_TGT = CNT_W'(RUN_LEN);

    err_flags_t flags_q;
    verdict_e   verd;

    assign verd = classify(rise_i, cnt_i == LEN_TGT);

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else
            flags_q <= next_flags(flags_q, verd);
    end

    assign pulse_o  = flags_q.pulse;
    assign sticky_o = flags_q.sticky;

    AST_MATCH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rise_i && cnt_i == LEN_TGT) |=> !pulse_o); // R5
    AST_MISS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (rise_i && cnt_i != LEN_TGT) |=> (pulse_o && sticky_o)); // R6
    AST_NO_EDGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rise_i |=> !pulse_o); // R8
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o); // R9
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        sticky_o |=> sticky_o); // R9
endmodule

// File: rtl/trig_prec_checker.sv
module trig_prec_checker #(
    parameter int  RUN_LEN = 4,
    localparam int CNT_W   = $clog2(RUN_LEN + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    input  logic             evt_i,
    output logic             err_sticky_o,
    output logic             err_pulse_o,
    output logic [CNT_W-1:0] run_cnt_o
);
    logic [CNT_W-1:0] cnt;
    logic             rise;

    trig_run_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .trig_i(trig_i),
        .cnt_o (cnt)
    );

    evt_edge_detect u_edge (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt_i),
        .rise_o(rise)
    );

    prec_verdict #(.CNT_W(CNT_W), .RUN_LEN(RUN_LEN)) u_verd (
        .clk     (clk),
        .rst     (rst),
        .rise_i  (rise),
        .cnt_i   (cnt),
        .pulse_o (err_pulse_o),
        .sticky_o(err_sticky_o)
    );

    assign run_cnt_o = cnt;

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (!err_pulse_o && !err_sticky_o && run_cnt_o == '0)); // R1
    AST_PULSE_IMPLIES_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_pulse_o |-> err_sticky_o); // R9
endmodule

// File: tb/trig_prec_checker_test.sv
`timescale 1ns/1ps
module trig_prec_checker_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trig = 1'b0;
    logic       evt = 1'b0;
    logic       sticky, pulse;
    logic [2:0] cnt;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trig_prec_checker uut (
        .clk(clk), .rst(rst), .trig_i(trig), .evt_i(evt),
        .err_sticky_o(sticky), .err_pulse_o(pulse), .run_cnt_o(cnt)
    );

    // Each entry: {trig, evt, count after edge, pulse after edge, sticky after edge}
    localparam int NV = 28;
    localparam logic [6:0] VEC [NV] = '{
        7'b1_0_001_0_0, 7'b1_0_010_0_0, 7'b1_0_011_0_0, 7'b1_0_100_0_0,
        7'b0_1_000_0_0, 7'b0_1_000_0_0, 7'b0_0_000_0_0,
        7'b1_0_001_0_0, 7'b1_0_010_0_0, 7'b1_0_011_0_0,
        7'b1_1_100_1_1, 7'b1_1_101_0_1, 7'b0_0_000_0_1,
        7'b1_0_001_0_1, 7'b1_0_010_0_1, 7'b1_0_011_0_1, 7'b1_0_100_0_1,
        7'b1_0_101_0_1, 7'b0_1_000_1_1, 7'b0_0_000_0_1,
        7'b1_1_001_1_1, 7'b0_0_000_0_1,
        7'b1_0_001_0_1, 7'b1_0_010_0_1, 7'b1_0_011_0_1, 7'b1_0_100_0_1,
        7'b1_1_101_0_1, 7'b0_0_000_0_1
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic t, input logic e);
        trig = t;
        evt  = e;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic e);
        rst  = 1'b1;
        trig = 1'b0;
        evt  = e;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        chk("R1 count", int'(cnt), 0);
        chk("R1 pulse", int'(pulse), 0);
        chk("R1 sticky", int'(sticky), 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][6], VEC[i][5]);
            chk($sformatf("R2/R3 count v%0d", i), int'(cnt), int'(VEC[i][4:2]));
            chk($sformatf("R5/R6/R7/R8 pulse v%0d", i), int'(pulse), int'(VEC[i][1]));
            chk($sformatf("R9 sticky v%0d", i), int'(sticky), int'(VEC[i][0]));
        end

        // R1: reset clears the sticky flag left by the table
        do_reset(1'b0);
        chk("R1 sticky cleared", int'(sticky), 0);
        chk("R1 count cleared", int'(cnt), 0);

        // R4: long run saturates at 7
        for (int k = 1; k <= 9; k++) begin
            step(1'b1, 1'b0);
            if (k == 7 || k == 9) chk("R4 saturate", int'(cnt), 7);
        end
        step(1'b0, 1'b1);
        chk("R7 edge after saturated run pulse", int'(pulse), 1);
        chk("R7 edge after saturated run sticky", int'(sticky), 1);
        step(1'b0, 1'b1);
        chk("R9 pulse single", int'(pulse), 0);
        chk("R9 sticky held", int'(sticky), 1);

        // R10: event held high through reset is no edge
        do_reset(1'b1);
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b1);
            chk("R10 held event pulse", int'(pulse), 0);
            chk("R10 held event sticky", int'(sticky), 0);
        end
        step(1'b0, 1'b0);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk("R5 exact run after reset", int'(pulse), 0);
        chk("R5 exact run sticky", int'(sticky), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule